// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the immediate-type vector configuration instruction. A decoder hands it the destination and source register indices, the source operand value and the requested type immediate. The block keeps the architectural vector length and vector type as state. When a valid strobe arrives, it works out the new length and type and updates that state on the next clock edge. In the same cycle it gives the integer writeback value and its enable.

The upper bound on the length is computed from the element width and the register grouping. The grouping can be an integer multiplier of 1, 2, 4 or 8, or a fraction of 1/2, 1/4 or 1/8. Any request the block cannot honour sets the illegal flag. This covers reserved encodings, an element width wider than the widest supported element, and a grouping that leaves no element. It also covers misuse of the keep-length form, in which both register indices are zero. That form may only run when the limit stays the same and the previous type was legal.

Top module: `vcfg_unit`

## Requirements
- R1: During and after reset, `vl` is 0 and `vtype` holds only the illegal flag. The illegal flag is bit XLEN-1 of `vtype`.
- R2: When `rs1_idx` is nonzero, the requested length is `rs1_val` and the new length is the smaller of that value and the limit. A nonzero `rd_idx` receives the new length.
- R3: When `rs1_idx` is zero and `rd_idx` is nonzero, the new length is the limit, and `rd_data` carries the limit with `rd_we` high in the strobe cycle.
- R4: When both indices are zero, the previous type is legal and the limit is unchanged, the length is kept, the type is updated and `rd_we` stays low.
- R5: When both indices are zero and the requested type gives a different limit than the current type, the illegal flag is set.
- R6: When both indices are zero and the illegal flag was already set, it stays set.
- R7: The limit equals (VLEN / SEW) times the grouping. The grouping field, bits [2:0] of the immediate, uses 0..3 for ×1, ×2, ×4 and ×8, and 7, 6 and 5 for ×1/2, ×1/4 and ×1/8. The width field, bits [5:3], uses 0..3 for 8, 16, 32 and 64 bits.
- R8: Each of the following sets the illegal flag: grouping code 4, a width code above the widest supported element, any nonzero immediate bit above bit 7, or a limit that computes to zero.
- R9: While the illegal flag is set, every other `vtype` bit is 0 and `vl` is 0. A nonzero `rd_idx` receives 0.
- R10: Without `in_valid`, `vl` and `vtype` do not change and `rd_we` is low.
- R11: A legal update copies immediate bits [7:0] into `vtype` [7:0]. These are grouping [2:0], width [5:3], tail policy 6 and mask policy 7, with all bits above them cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| in_valid | input | 1 | Instruction strobe |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | Source register index |
| rs1_val | input | XLEN | Source operand, the requested length |
| vtypei | input | IMM_W | Requested type immediate |
| rd_we | output | 1 | Integer writeback enable |
| rd_data | output | XLEN | Integer writeback value |
| vl | output | XLEN | Current vector length |
| vtype | output | XLEN | Current vector type, illegal flag in the top bit |

## Verification
Directed instructions cover each operand form in turn. A bounded request separates the minimum from a plain copy of the limit, while a zero source with a nonzero destination shows the limit being written back. Keep-length instructions come in three kinds: one that keeps the limit, one that keeps it through a changed width and grouping pair, and one that shrinks it. Together these separate comparing the limit from comparing the raw fields. Fractional groupings, reserved codes, idle cycles with junk inputs and a long pseudo-random instruction stream are compared against a behavioural model every cycle.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  // low byte of the type register, msb first
  typedef struct packed {
    logic       vma;
    logic       vta;
    logic [2:0] vsew;
    logic [2:0] vlmul;
  } vtype_fields_t;

  localparam int unsigned FIELD_W = 8;
  localparam logic [2:0] VLMUL_RSVD = 3'b100;

endpackage

// File: rtl/vcfg_vlmax_calc.sv
module vcfg_vlmax_calc #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = $clog2(VLEN) + 1
) (
  input  logic [2:0]      vsew,
  input  logic [2:0]      vlmul,
  output logic [VL_W-1:0] vlmax
);

  logic [3:0]      shamt;
  logic [VL_W-1:0] per_reg;

  always_comb begin
    shamt   = {1'b0, vsew} + 4'd3;
    per_reg = VL_W'(VLEN) >> shamt;
    if (!vlmul[2]) begin
      vlmax = per_reg << vlmul[1:0];
    end else begin
      // 5 -> /8, 6 -> /4, 7 -> /2
      vlmax = per_reg >> (3'd4 - {1'b0, vlmul[1:0]});
    end
  end

endmodule

// File: rtl/vcfg_vtype_check.sv
module vcfg_vtype_check #(
  parameter int unsigned ELEN  = 64,
  parameter int unsigned IMM_W = 11,
  parameter int unsigned VL_W  = 8
) (
  input  logic [IMM_W-9:0] rsvd_bits,
  input  logic [2:0]       vsew,
  input  logic [2:0]       vlmul,
  input  logic [VL_W-1:0]  vlmax,
  output logic             req_ok
);
  import vcfg_pkg::*;

  localparam logic [2:0] MAX_SEW_CODE = 3'($clog2(ELEN / 8));

  always_comb begin
    req_ok = (rsvd_bits == '0)
          && (vlmul != VLMUL_RSVD)
          && (vsew <= MAX_SEW_CODE)
          && (vlmax != '0);
  end

endmodule

// File: rtl/vcfg_next.sv
module vcfg_next #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VL_W = 8
) (
  input  logic                          in_valid,
  input  logic [4:0]                    rd_idx,
  input  logic [4:0]                    rs1_idx,
  input  logic [XLEN-1:0]               rs1_val,
  input  vcfg_pkg::vtype_fields_t       req_fld,
  input  logic                          req_ok,
  input  logic [VL_W-1:0]               vlmax_new,
  input  logic [VL_W-1:0]               vlmax_cur,
  input  logic [VL_W-1:0]               vl_q,
  input  logic                          vill_q,
  output logic [VL_W-1:0]               vl_d,
  output logic                          vill_d,
  output vcfg_pkg::vtype_fields_t       fld_d,
  output logic                          rd_we,
  output logic [XLEN-1:0]               rd_data
);

  logic            rs1_zero;
  logic            rd_zero;
  logic            keep_form;
  logic            keep_bad;
  logic [VL_W-1:0] len;
  logic            ok;

  always_comb begin
    rs1_zero  = (rs1_idx == 5'd0);
    rd_zero   = (rd_idx == 5'd0);
    keep_form = rs1_zero && rd_zero;
    keep_bad  = keep_form && (vill_q || (vlmax_new != vlmax_cur));

    if (!rs1_zero) begin
      len = (rs1_val < XLEN'(vlmax_new)) ? rs1_val[VL_W-1:0] : vlmax_new;
    end else if (!rd_zero) begin
      len = vlmax_new;
    end else begin
      len = vl_q;
    end

    ok      = req_ok && !keep_bad;
    vill_d  = !ok;
    vl_d    = ok ? len : '0;
    fld_d   = ok ? req_fld : '0;
    rd_we   = in_valid && !rd_zero;
    rd_data = XLEN'(vl_d);
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned VLEN  = 128,
  parameter int unsigned ELEN  = 64,
  parameter int unsigned IMM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       rd_idx,
  input  logic [4:0]       rs1_idx,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [IMM_W-1:0] vtypei,
  output logic             rd_we,
  output logic [XLEN-1:0]  rd_data,
  output logic [XLEN-1:0]  vl,
  output logic [XLEN-1:0]  vtype
);
  import vcfg_pkg::*;

  localparam int unsigned VL_W  = $clog2(VLEN) + 1;
  localparam int unsigned PAD_W = XLEN - 1 - FIELD_W;

  vtype_fields_t   req_fld;
  vtype_fields_t   fld_q, fld_d;
  logic [VL_W-1:0] vl_q, vl_d;
  logic            vill_q, vill_d;
  logic            req_ok;

  // index 0: requested type, index 1: current type
  logic [2:0]      sel_sew   [2];
  logic [2:0]      sel_lmul  [2];
  logic [VL_W-1:0] sel_vlmax [2];

  assign req_fld     = vtype_fields_t'(vtypei[FIELD_W-1:0]);
  assign sel_sew[0]  = req_fld.vsew;
  assign sel_lmul[0] = req_fld.vlmul;
  assign sel_sew[1]  = fld_q.vsew;
  assign sel_lmul[1] = fld_q.vlmul;

  for (genvar g = 0; g < 2; g++) begin : g_limit
    vcfg_vlmax_calc #(.VLEN(VLEN), .VL_W(VL_W)) u_calc (
      .vsew  (sel_sew[g]),
      .vlmul (sel_lmul[g]),
      .vlmax (sel_vlmax[g])
    );
  end

  vcfg_vtype_check #(.ELEN(ELEN), .IMM_W(IMM_W), .VL_W(VL_W)) u_chk (
    .rsvd_bits (vtypei[IMM_W-1:FIELD_W]),
    .vsew      (req_fld.vsew),
    .vlmul     (req_fld.vlmul),
    .vlmax     (sel_vlmax[0]),
    .req_ok    (req_ok)
  );

  vcfg_next #(.XLEN(XLEN), .VL_W(VL_W)) u_nxt (
    .in_valid  (in_valid),
    .rd_idx    (rd_idx),
    .rs1_idx   (rs1_idx),
    .rs1_val   (rs1_val),
    .req_fld   (req_fld),
    .req_ok    (req_ok),
    .vlmax_new (sel_vlmax[0]),
    .vlmax_cur (sel_vlmax[1]),
    .vl_q      (vl_q),
    .vill_q    (vill_q),
    .vl_d      (vl_d),
    .vill_d    (vill_d),
    .fld_d     (fld_d),
    .rd_we     (rd_we),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= '0;
      vill_q <= 1'b1;
      fld_q  <= '0;
    end else if (in_valid) begin
      vl_q   <= vl_d;
      vill_q <= vill_d;
      fld_q  <= fld_d;
    end
  end

  assign vl    = XLEN'(vl_q);
  assign vtype = {vill_q, {PAD_W{1'b0}}, fld_q};

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(vl) && $stable(vtype)));

  p_ill_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vtype[XLEN-1] |-> (vl == '0 && vtype[XLEN-2:0] == '0));

  p_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_idx == 5'd0) |-> !rd_we);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_idx == 5'd0 && rs1_idx == 5'd0 && vtype[XLEN-1]) |=> vtype[XLEN-1]);

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rs1_idx != 5'd0) |=> (vl <= $past(rs1_val)));

  p_wb_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |=> (vl == $past(rd_data)));

  p_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vl <= XLEN'(VLEN));

endmodule

// File: tb/vcfg_unit_tb_top.sv
`timescale 1ns/1ps
module vcfg_unit_tb_top;

  localparam int XLEN  = 64;
  localparam int VLEN  = 128;
  localparam int IMM_W = 11;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [4:0]       rd_idx, rs1_idx;
  logic [XLEN-1:0]  rs1_val;
  logic [IMM_W-1:0] vtypei;
  logic             rd_we;
  logic [XLEN-1:0]  rd_data, vl, vtype;

  int n_cmp = 0;
  int n_mis = 0;

  int        m_vl;
  bit        m_vill;
  bit [7:0]  m_fld;
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .IMM_W(IMM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_idx(rd_idx),
    .rs1_idx(rs1_idx), .rs1_val(rs1_val), .vtypei(vtypei),
    .rd_we(rd_we), .rd_data(rd_data), .vl(vl), .vtype(vtype)
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int limit_of(int sew, int lm);
    int per;
    per = VLEN / (8 * (1 << sew));
    if (lm < 4) return per * (1 << lm);
    return per / (1 << (8 - lm));
  endfunction

  function automatic logic [XLEN-1:0] m_vtype();
    return {m_vill, 55'd0, m_fld};
  endfunction

  function automatic logic [IMM_W-1:0] imm(int sew, int lm, bit ta, bit ma);
    return IMM_W'({ma, ta, 3'(sew), 3'(lm)});
  endfunction

  task automatic issue(string tag, int rd, int rs1, longint unsigned val,
                       logic [IMM_W-1:0] ti);
    int  sew, lm, lim, cur, len;
    bit  ok;
    @(negedge clk);
    in_valid = 1'b1; rd_idx = 5'(rd); rs1_idx = 5'(rs1);
    rs1_val = val; vtypei = ti;
    sew = int'(ti[5:3]); lm = int'(ti[2:0]);
    lim = (sew <= 3) ? limit_of(sew, lm) : 0;
    cur = limit_of(int'(m_fld[5:3]), int'(m_fld[2:0]));
    ok  = (ti[IMM_W-1:8] == 0) && (lm != 4) && (sew <= 3) && (lim != 0);
    if (rs1 != 0)     len = (val < longint'(lim)) ? int'(val) : lim;
    else if (rd != 0) len = lim;
    else begin
      len = m_vl;
      if (m_vill || lim != cur) ok = 0;
    end
    if (!ok) len = 0;
    #1;
    chk({tag, " rd_we"}, XLEN'(rd_we), XLEN'(rd != 0));
    if (rd != 0) chk({tag, " rd_data"}, rd_data, XLEN'(len));
    @(posedge clk); #1;
    m_vill = !ok;
    m_vl   = len;
    m_fld  = ok ? ti[7:0] : 8'h00;
    chk({tag, " vl"}, vl, XLEN'(m_vl));
    chk({tag, " vtype"}, vtype, m_vtype());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; rd_idx = 5'd7; rs1_idx = 5'd0;
      rs1_val = 64'd3; vtypei = imm(3, 1, 0, 0);
      #1; chk("R10 rd_we", XLEN'(rd_we), '0);
      @(posedge clk); #1;
      chk("R10 vl", vl, XLEN'(m_vl));
      chk("R10 vtype", vtype, m_vtype());
    end
  endtask

  function automatic int unsigned nxt_rand();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    #1_000_000;
    n_mis++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; rd_idx = '0; rs1_idx = '0;
    rs1_val = '0; vtypei = '0;
    m_vl = 0; m_vill = 1; m_fld = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vl in reset", vl, '0);
    chk("R1 vtype in reset", vtype, 64'h8000_0000_0000_0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 vtype after release", vtype, 64'h8000_0000_0000_0000);

    issue("R6 keep-form after reset", 0, 0, 0, imm(0, 0, 0, 0));
    issue("R3 set max e64 m8", 5, 0, 0, imm(3, 3, 0, 0));
    issue("R4 keep e64 m8", 0, 0, 0, imm(3, 3, 0, 0));
    issue("R5 shrink to e64 m1", 0, 0, 0, imm(3, 0, 0, 0));
    issue("R6 keep-form stays illegal", 0, 0, 0, imm(3, 0, 0, 0));
    issue("R2 avl above limit", 3, 4, 10, imm(2, 0, 0, 0));
    issue("R2 avl below limit", 3, 4, 3, imm(0, 1, 0, 0));
    issue("R7 half grouping", 9, 2, 1000, imm(1, 7, 0, 0));
    issue("R7 eighth grouping", 9, 2, 100, imm(0, 5, 0, 0));
    issue("R8 zero limit", 9, 2, 100, imm(3, 5, 0, 0));
    issue("R8 grouping code 4", 9, 0, 0, imm(0, 4, 0, 0));
    issue("R8 wide element", 9, 0, 0, imm(4, 0, 0, 0));
    issue("R8 reserved bit", 9, 0, 0, IMM_W'(11'h100) | imm(0, 0, 0, 0));
    issue("R11 policies set", 6, 0, 0, imm(1, 2, 1, 1));
    issue("R2 e16 m2 avl 8", 6, 1, 8, imm(1, 1, 0, 0));
    issue("R4 same ratio e32 m4", 0, 0, 0, imm(2, 2, 1, 0));
    issue("R9 illegal with rd", 4, 3, 5, imm(7, 0, 0, 0));
    idle(4);
    issue("R3 after illegal", 1, 0, 0, imm(2, 6, 0, 1));
    idle(2);

    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      int rd, rs1;
      longint unsigned v;
      logic [IMM_W-1:0] ti;
      r   = nxt_rand();
      rd  = (r[2:0] < 3) ? 0 : int'(r[7:3]);
      rs1 = (r[10:8] < 4) ? 0 : int'(r[15:11]);
      v   = r[16] ? longint'(r[23:17]) : {32'd0, nxt_rand()};
      ti  = IMM_W'(nxt_rand());
      if (ti[10:8] != 0 && r[27:24] != 0) ti[10:8] = 3'd0;
      issue("R2 R3 R4 R5 R8 stream", rd, rs1, v, ti);
      if (r[31:29] == 0) idle(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule